// File: doc/BRIEF.md
# Queued APB Write Requester

This block sits on the requester side of an APB bus and turns a stream of write commands into bus write transfers. Each command carries an address, write data, byte strobes and protection bits and is handed over through a valid/ready pair. A small field of the address picks one of several peripheral slots. The block raises that slot's select line, runs the one-cycle setup phase and the access phase, and ends the transfer when the slot reports ready.

Each finished transfer produces a one-cycle status pulse. The pulse carries an error bit, plus a second bit that marks a transfer ended by the wait-cycle timeout. When the command that follows goes to the same slot, the select line stays high and only enable drops for one new setup cycle. When it goes to another slot, all selects drop for one idle cycle. Slots marked in a parameter mask are older peripherals with no ready or error outputs. For these the ready input counts as always high and the error input counts as always low.

Top module: `apb_wr_requester`

## Requirements
- R1: After a command is accepted, the next cycle is a setup cycle with exactly one select bit high and enable low. Enable is high in the cycle after that.
- R2: An access cycle is the completing cycle when the selected slot's effective ready is high. Each access cycle with effective ready low adds one more access cycle.
- R3: The following hold their values from the setup cycle through the completing cycle, wait cycles included: address, write data, strobes, protection, select, and write direction (high).
- R4: If a command is accepted in the completing cycle and targets the same slot, select stays high in the next cycle while enable is low for that one setup cycle.
- R5: If a command accepted in the completing cycle targets a different slot, the next cycle has all selects low and enable low. The setup cycle for the new slot follows it.
- R6: A slot whose bit is set in LEGACY_MASK (default: slot 3 only) completes on its first access cycle whatever its ready input is. Its error input never sets the error status.
- R7: The slot's error input is sampled only in the completing cycle. A high error input during wait cycles has no effect on the status.
- R8: cmd_ready is high only when the block is idle or in a completing cycle. During setup and wait cycles it is low and the bus fields keep the current transfer.
- R9: After WAIT_LIMIT (default 16) consecutive access cycles with effective ready low, the transfer ends on that last cycle. The status then reports both error and timeout.
- R10: done_valid is high for exactly one cycle, the cycle after the completing edge, with done_err and done_timeout valid alongside it. Synchronous reset leaves select, enable and done_valid low and cmd_ready high.
- R11: The slot number is address bits [SLOT_LSB +: log2(NSLOT)] (default bits 13:12). Select bit k is driven for slot k.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Write command offered |
| cmd_ready | output | 1 | Command taken on this edge when valid is high |
| cmd_addr | input | ADDR_W | Command address, includes the slot field |
| cmd_data | input | DATA_W | Command write data |
| cmd_strb | input | DATA_W/8 | Command byte strobes |
| cmd_prot | input | 3 | Command protection bits |
| psel | output | NSLOT | One select line per slot |
| penable | output | 1 | Access-phase enable |
| paddr | output | ADDR_W | Bus address |
| pwrite | output | 1 | Write direction, high during transfers |
| pwdata | output | DATA_W | Bus write data |
| pstrb | output | DATA_W/8 | Bus byte strobes |
| pprot | output | 3 | Bus protection bits |
| pready | input | NSLOT | Ready from each slot |
| pslverr | input | NSLOT | Error from each slot |
| done_valid | output | 1 | One-cycle completion pulse |
| done_err | output | 1 | Completion with slave error or timeout |
| done_timeout | output | 1 | Completion caused by the wait timeout |

## Verification
Isolated writes are driven with zero wait cycles, several wait cycles, and more wait cycles than the limit. Comparing these separates ready-driven completion from timeout-driven completion and confirms the fields stay fixed across each length. The error input is raised either only in the completing cycle or only during the waits, which shows whether it is sampled at the right moment. A legacy slot is driven with ready low and error high to show that both are overridden. Pairs of commands go first to the same slot and then to different slots, with the second command held valid from the first one's setup onward. This tells the chained path apart from the idle-gap path and shows that no command is taken mid-transfer.

// File: rtl/apb_wr_pkg.sv
package apb_wr_pkg;

    localparam int PROT_W = 3;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_SETUP  = 2'd1,
        ST_ACCESS = 2'd2,
        ST_GAP    = 2'd3
    } wr_state_e;

    typedef struct packed {
        logic valid;
        logic err;
        logic tmo;
    } wr_status_t;

    function automatic logic is_bus_active(input wr_state_e s);
        return (s == ST_SETUP) || (s == ST_ACCESS);
    endfunction

endpackage

// File: rtl/apb_slot_resp.sv
module apb_slot_resp #(
    parameter int          NSLOT       = 4,
    parameter int          SLOT_W      = 2,
    parameter logic [NSLOT-1:0] LEGACY_MASK = '0
) (
    input  logic [SLOT_W-1:0] slot,
    input  logic [NSLOT-1:0]  pready,
    input  logic [NSLOT-1:0]  pslverr,
    output logic              eff_ready,
    output logic              eff_err
);
    logic [NSLOT-1:0] rdy_v;
    logic [NSLOT-1:0] err_v;

    generate
        for (genvar i = 0; i < NSLOT; i++) begin : g_slot
            if (LEGACY_MASK[i]) begin : g_old
                logic unused_legacy_in;
                assign unused_legacy_in = pready[i] ^ pslverr[i];
                assign rdy_v[i] = 1'b1;
                assign err_v[i] = 1'b0;
            end else begin : g_new
                assign rdy_v[i] = pready[i];
                assign err_v[i] = pslverr[i];
            end
        end
    endgenerate

    assign eff_ready = rdy_v[slot];
    assign eff_err   = err_v[slot];
endmodule

// File: rtl/apb_wait_timer.sv
module apb_wait_timer #(
    parameter int WAIT_LIMIT = 16
) (
    input  logic clk,
    input  logic rst,
    input  logic clear,
    input  logic tick,
    output logic expired
);
    localparam int CNT_W = $clog2(WAIT_LIMIT + 1);

    logic [CNT_W-1:0] cnt;

    assign expired = tick && (cnt == CNT_W'(WAIT_LIMIT - 1));

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            cnt <= '0;
        end else if (tick && !expired) begin
            cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/apb_wr_fsm.sv
module apb_wr_fsm
    import apb_wr_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      cmd_valid,
    input  logic      same_slot,
    input  logic      eff_ready,
    input  logic      expired,
    output wr_state_e state,
    output logic      cmd_ready,
    output logic      take,
    output logic      complete
);
    wr_state_e nxt;

    assign complete  = (state == ST_ACCESS) && (eff_ready || expired);
    assign cmd_ready = (state == ST_IDLE) || complete;
    assign take      = cmd_valid && cmd_ready;

    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:   if (take) nxt = ST_SETUP;
            ST_SETUP:  nxt = ST_ACCESS;
            ST_ACCESS: begin
                if (complete) begin
                    if (!take)          nxt = ST_IDLE;
                    else if (same_slot) nxt = ST_SETUP;
                    else                nxt = ST_GAP;
                end
            end
            ST_GAP:    nxt = ST_SETUP;
            default:   nxt = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state <= ST_IDLE;
        else     state <= nxt;
    end
endmodule

// File: rtl/apb_wr_requester.sv
module apb_wr_requester
    import apb_wr_pkg::*;
#(
    parameter int               ADDR_W      = 16,
    parameter int               DATA_W      = 32,
    parameter int               NSLOT       = 4,
    parameter int               SLOT_LSB    = 12,
    parameter int               WAIT_LIMIT  = 16,
    parameter logic [NSLOT-1:0] LEGACY_MASK = 4'b1000
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                cmd_valid,
    output logic                cmd_ready,
    input  logic [ADDR_W-1:0]   cmd_addr,
    input  logic [DATA_W-1:0]   cmd_data,
    input  logic [DATA_W/8-1:0] cmd_strb,
    input  logic [2:0]          cmd_prot,
    output logic [NSLOT-1:0]    psel,
    output logic                penable,
    output logic [ADDR_W-1:0]   paddr,
    output logic                pwrite,
    output logic [DATA_W-1:0]   pwdata,
    output logic [DATA_W/8-1:0] pstrb,
    output logic [2:0]          pprot,
    input  logic [NSLOT-1:0]    pready,
    input  logic [NSLOT-1:0]    pslverr,
    output logic                done_valid,
    output logic                done_err,
    output logic                done_timeout
);
    localparam int SLOT_W = (NSLOT > 1) ? $clog2(NSLOT) : 1;
    localparam int STRB_W = DATA_W / 8;

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
        logic [STRB_W-1:0] strb;
        logic [PROT_W-1:0] prot;
        logic [SLOT_W-1:0] slot;
    } wr_cmd_t;

    wr_cmd_t    cur;
    wr_cmd_t    incoming;
    wr_state_e  state;
    wr_status_t status;
    logic       take, complete, same_slot, eff_ready, eff_err, expired, active;

    assign incoming.addr = cmd_addr;
    assign incoming.data = cmd_data;
    assign incoming.strb = cmd_strb;
    assign incoming.prot = cmd_prot;
    assign incoming.slot = cmd_addr[SLOT_LSB +: SLOT_W];
    assign same_slot     = (incoming.slot == cur.slot);

    apb_wr_fsm u_fsm (
        .clk       (clk),
        .rst       (rst),
        .cmd_valid (cmd_valid),
        .same_slot (same_slot),
        .eff_ready (eff_ready),
        .expired   (expired),
        .state     (state),
        .cmd_ready (cmd_ready),
        .take      (take),
        .complete  (complete)
    );

    apb_slot_resp #(
        .NSLOT       (NSLOT),
        .SLOT_W      (SLOT_W),
        .LEGACY_MASK (LEGACY_MASK)
    ) u_resp (
        .slot      (cur.slot),
        .pready    (pready),
        .pslverr   (pslverr),
        .eff_ready (eff_ready),
        .eff_err   (eff_err)
    );

    apb_wait_timer #(
        .WAIT_LIMIT (WAIT_LIMIT)
    ) u_timer (
        .clk     (clk),
        .rst     (rst),
        .clear   (state != ST_ACCESS),
        .tick    ((state == ST_ACCESS) && !eff_ready),
        .expired (expired)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            cur <= '0;
        end else if (take) begin
            cur <= incoming;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            status <= '0;
        end else begin
            status.valid <= complete;
            status.err   <= complete && (eff_err || expired);
            status.tmo   <= complete && expired;
        end
    end

    assign active = is_bus_active(state);

    generate
        for (genvar k = 0; k < NSLOT; k++) begin : g_sel
            assign psel[k] = active && (cur.slot == SLOT_W'(k));
        end
    endgenerate

    assign penable      = (state == ST_ACCESS);
    assign pwrite       = active;
    assign paddr        = cur.addr;
    assign pwdata       = cur.data;
    assign pstrb        = cur.strb;
    assign pprot        = cur.prot;
    assign done_valid   = status.valid;
    assign done_err     = status.err;
    assign done_timeout = status.tmo;
endmodule

// File: rtl/apb_wr_checker.sv
module apb_wr_checker #(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 32,
    parameter int NSLOT  = 4
) (
    input logic                clk,
    input logic                rst,
    input logic                cmd_ready,
    input logic [NSLOT-1:0]    psel,
    input logic                penable,
    input logic [ADDR_W-1:0]   paddr,
    input logic                pwrite,
    input logic [DATA_W-1:0]   pwdata,
    input logic [DATA_W/8-1:0] pstrb,
    input logic [2:0]          pprot,
    input logic                done_valid
);
    AST_SETUP_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        (|psel && !penable) |=> (penable && psel == $past(psel))); // R1

    AST_EN_HAS_SEL: assert property (@(posedge clk) disable iff (rst)
        penable |-> (|psel)); // R2

    AST_HOLD_INTO_ACCESS: assert property (@(posedge clk) disable iff (rst)
        (|psel && !penable) |=> ($stable(paddr) && $stable(pwdata) && $stable(pstrb)
                                 && $stable(pprot) && pwrite)); // R3

    AST_HOLD_IN_WAIT: assert property (@(posedge clk) disable iff (rst)
        (penable && $past(penable)) |-> ($stable(paddr) && $stable(pwdata) && $stable(pstrb)
                                         && $stable(pprot) && $stable(psel) && pwrite)); // R3

    AST_EN_LOW_AFTER_DONE: assert property (@(posedge clk) disable iff (rst)
        done_valid |-> !penable); // R4

    AST_SEL_NO_SWAP: assert property (@(posedge clk) disable iff (rst)
        (|psel && |$past(psel)) |-> (psel == $past(psel))); // R5

    AST_ACCEPT_AT_END: assert property (@(posedge clk) disable iff (rst)
        (cmd_ready && penable) |=> done_valid); // R8

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
        done_valid |=> !done_valid); // R10

    AST_SEL_ONEHOT: assert property (@(posedge clk) disable iff (rst)
        $onehot0(psel)); // R11
endmodule

bind apb_wr_requester apb_wr_checker #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W),
    .NSLOT  (NSLOT)
) u_chk (
    .clk        (clk),
    .rst        (rst),
    .cmd_ready  (cmd_ready),
    .psel       (psel),
    .penable    (penable),
    .paddr      (paddr),
    .pwrite     (pwrite),
    .pwdata     (pwdata),
    .pstrb      (pstrb),
    .pprot      (pprot),
    .done_valid (done_valid)
);

// File: tb/apb_wr_requester_test.sv
`timescale 1ns/1ps
module apb_wr_requester_test;
    localparam int LIMIT = 16;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cmd_valid = 1'b0;
    logic        cmd_ready;
    logic [15:0] cmd_addr = '0;
    logic [31:0] cmd_data = '0;
    logic [3:0]  cmd_strb = '0;
    logic [2:0]  cmd_prot = '0;
    logic [3:0]  psel;
    logic        penable;
    logic [15:0] paddr;
    logic        pwrite;
    logic [31:0] pwdata;
    logic [3:0]  pstrb;
    logic [2:0]  pprot;
    logic [3:0]  pready = '0;
    logic [3:0]  pslverr = '0;
    logic        done_valid, done_err, done_timeout;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    apb_wr_requester uut (
        .clk(clk), .rst(rst),
        .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
        .cmd_addr(cmd_addr), .cmd_data(cmd_data), .cmd_strb(cmd_strb), .cmd_prot(cmd_prot),
        .psel(psel), .penable(penable), .paddr(paddr), .pwrite(pwrite),
        .pwdata(pwdata), .pstrb(pstrb), .pprot(pprot),
        .pready(pready), .pslverr(pslverr),
        .done_valid(done_valid), .done_err(done_err), .done_timeout(done_timeout)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic eq(input string req, input string what, input longint act, input longint exp);
        chk(act == exp, req, what, act, exp);
    endtask

    // One isolated write; waits = access cycles with ready low before ready.
    // err_at_end: error high in completing cycle; err_in_wait: error high only while waiting.
    task automatic run_one(input logic [15:0] a, input logic [31:0] d, input logic [3:0] s,
                           input logic [2:0] p, input int waits, input bit err_at_end,
                           input bit err_in_wait, input bit legacy, input bit exp_err,
                           input bit exp_tmo, input string req);
        int sl;
        int last;
        sl = int'(a[13:12]);
        if (legacy) last = 0;
        else if (waits >= LIMIT) last = LIMIT - 1;
        else last = waits;
        @(negedge clk);
        cmd_valid = 1'b1; cmd_addr = a; cmd_data = d; cmd_strb = s; cmd_prot = p;
        #1;
        eq("R8", "idle cmd_ready", cmd_ready, 1);
        @(negedge clk);
        cmd_valid = 1'b0;
        if (legacy) begin pready[sl] = 1'b0; pslverr[sl] = 1'b1; end
        #1;
        eq("R1", "setup psel", psel, 4'b1 << sl);
        eq("R1", "setup penable", penable, 0);
        eq("R11", "setup paddr", paddr, a);
        eq("R3", "setup pwdata", pwdata, d);
        eq("R3", "setup pstrb/pprot", {pstrb, pprot}, {s, p});
        eq("R3", "setup pwrite", pwrite, 1);
        eq("R8", "setup cmd_ready", cmd_ready, 0);
        for (int k = 0; k <= last; k++) begin
            @(negedge clk);
            if (!legacy) begin
                pready[sl]  = (k >= waits);
                pslverr[sl] = (k >= waits) ? err_at_end : err_in_wait;
            end
            #1;
            eq(req, "access penable", penable, 1);
            eq("R3", "access psel", psel, 4'b1 << sl);
            eq("R3", "access paddr", paddr, a);
            eq("R3", "access pwdata", pwdata, d);
            eq(req, "access cmd_ready", cmd_ready, (k == last));
            eq("R10", "no early done", done_valid, 0);
        end
        @(negedge clk);
        pready = '0; pslverr = '0;
        #1;
        eq("R10", "done_valid", done_valid, 1);
        eq(req, "done_err", done_err, exp_err);
        eq(req, "done_timeout", done_timeout, exp_tmo);
        eq("R10", "idle psel", psel, 0);
        eq("R10", "idle penable", penable, 0);
        @(negedge clk); #1;
        eq("R10", "done one cycle", done_valid, 0);
    endtask

    // Two commands; the second is offered from the first one's setup cycle.
    task automatic run_pair(input logic [15:0] a1, input logic [31:0] d1,
                            input logic [15:0] a2, input logic [31:0] d2);
        int s1;
        int s2;
        bit same;
        s1 = int'(a1[13:12]);
        s2 = int'(a2[13:12]);
        same = (s1 == s2);
        @(negedge clk);
        cmd_valid = 1'b1; cmd_addr = a1; cmd_data = d1; cmd_strb = 4'hF; cmd_prot = 3'd2;
        @(negedge clk);
        cmd_addr = a2; cmd_data = d2; cmd_strb = 4'h3; cmd_prot = 3'd5;
        #1;
        eq("R8", "pair setup cmd_ready", cmd_ready, 0);
        eq("R8", "pair setup paddr", paddr, a1);
        @(negedge clk);
        pready[s1] = 1'b0;
        #1;
        eq("R8", "pair wait cmd_ready", cmd_ready, 0);
        eq("R8", "pair wait paddr", paddr, a1);
        eq("R3", "pair wait pwdata", pwdata, d1);
        @(negedge clk);
        pready[s1] = 1'b1;
        #1;
        eq("R8", "pair end cmd_ready", cmd_ready, 1);
        @(negedge clk);
        cmd_valid = 1'b0; pready = '0;
        #1;
        eq("R10", "pair first done", done_valid, 1);
        eq(same ? "R4" : "R5", "after first penable", penable, 0);
        if (same) begin
            eq("R4", "chained psel held", psel, 4'b1 << s1);
            eq("R4", "chained paddr", paddr, a2);
        end else begin
            eq("R5", "gap psel low", psel, 0);
            @(negedge clk); #1;
            eq("R5", "new slot setup psel", psel, 4'b1 << s2);
            eq("R5", "new slot setup penable", penable, 0);
            eq("R5", "new slot paddr", paddr, a2);
        end
        @(negedge clk);
        pready[s2] = 1'b1;
        #1;
        eq(same ? "R4" : "R5", "second access penable", penable, 1);
        eq("R3", "second pwdata", pwdata, d2);
        eq("R3", "second pstrb/pprot", {pstrb, pprot}, {4'h3, 3'd5});
        eq("R2", "second cmd_ready", cmd_ready, 1);
        @(negedge clk);
        pready = '0;
        #1;
        eq("R10", "second done", done_valid, 1);
        eq("R7", "second done_err", done_err, 0);
        eq("R10", "idle psel", psel, 0);
    endtask

    task automatic t_reset;
        rst = 1'b1;
        repeat (3) @(negedge clk);
        #1;
        eq("R10", "reset psel", psel, 0);
        eq("R10", "reset penable", penable, 0);
        eq("R10", "reset done_valid", done_valid, 0);
        eq("R10", "reset cmd_ready", cmd_ready, 1);
        rst = 1'b0;
    endtask

    initial begin
        repeat (40000) @(posedge clk);
        checks++; errors++;
        $display("FAIL R10 watchdog actual=hung expected=finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        t_reset();
        // R1 R2 R11: slot 0, no waits
        run_one(16'h0123, 32'hA5A5_0001, 4'hF, 3'd0, 0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, "R2");
        // R2 R3: slot 1 with three wait cycles
        run_one(16'h1F04, 32'h1234_5678, 4'h6, 3'd3, 3, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, "R2");
        // R7: error at completion is reported
        run_one(16'h2010, 32'hDEAD_BEEF, 4'h1, 3'd1, 1, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, "R7");
        // R7: error only during waits is ignored
        run_one(16'h2014, 32'h0BAD_F00D, 4'h8, 3'd4, 2, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, "R7");
        // R6: legacy slot 3 with ready low and error high
        run_one(16'h3008, 32'h5555_AAAA, 4'hC, 3'd7, 0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, "R6");
        // R9: stuck slot times out
        run_one(16'h1100, 32'hCAFE_0009, 4'hF, 3'd2, 100, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, "R9");
        // R4: chained writes to slot 1
        run_pair(16'h1040, 32'h1111_1111, 16'h1044, 32'h2222_2222);
        // R5: slot 0 then slot 2
        run_pair(16'h0200, 32'h3333_3333, 16'h2300, 32'h4444_4444);
        repeat (2) @(negedge clk);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule